// File: doc/BRIEF.md
# Floating-Point Sticky Exception Flag Unit

This block sits beside a floating-point datapath and keeps the flag half of its control/status register. When an operation completes, the datapath pulses a done strobe together with a thirteen-bit cause vector. The unit folds that vector into eight sticky flags. Several causes feed more than one flag. For example, a signalling NaN raises both the generic invalid flag and the signalling-NaN flag.

The update happens only while the register's enable bit is set. After an update, if any flag is set, the unit raises a floating-point exception request to the exception controller for one cycle. The request carries the previous-PC value that was presented with the strobe.

Software reads the register through a read port and replaces it through a write port. A software write is the only way to clear flags, and it overrides a status update that arrives in the same cycle.

Register layout: bit 0 is the enable bit. Bits 8..1 hold the flags in this order: invalid (1), signalling NaN (2), quiet NaN (3), overflow (4), underflow (5), infinity (6), divide-by-zero (7), inexact (8).

Cause vector bits:
- 0: signalling NaN
- 1: quiet NaN
- 2: inf minus inf
- 3: inf divided by inf
- 4: zero divided by zero
- 5: inf times zero
- 6: invalid conversion
- 7: invalid compare
- 8: square root of a negative value
- 9: overflow
- 10: underflow
- 11: divide by zero
- 12: inexact

Top module: `fpx_sticky_flags`

## Requirements
- R1: While rst_ni is low, csr_o reads zero and exc_req_o is low.
- R2: A done strobe has no effect on csr_o and raises no request while csr_o bit 0 (enable) is clear.
- R3: With enable set, any of cause bits 0 through 8 sets the invalid flag (csr_o bit 1) on the clock edge that samples the strobe.
- R4: Cause bit 0 alone sets the signalling-NaN flag (csr_o bit 2). Cause bit 1 alone sets the quiet-NaN flag (csr_o bit 3). No other cause sets either flag.
- R5: Cause bit 2 or cause bit 3 sets the infinity flag (csr_o bit 6). No other cause sets it.
- R6: Cause bits 9, 10, 11 and 12 set, respectively, the overflow (bit 4), underflow (bit 5), divide-by-zero (bit 7) and inexact (bit 8) flags.
- R7: A flag that is set stays set across status updates; only a software write can clear it.
- R8: When csr_we_i is high, csr_o takes csr_wdata_i on the next edge. A strobe in the same cycle is discarded and raises no request.
- R9: In the cycle after an accepted strobe, exc_req_o pulses high for one cycle if any of the eight flags is set after the update, and exc_pc_o then equals prev_pc_i as sampled with the strobe.
- R10: exc_req_o stays low after an accepted strobe that leaves all eight flags clear, and in any cycle not preceded by a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_done_i | input | 1 | Operation-complete strobe from the datapath |
| op_cause_i | input | 13 | Per-operation cause vector |
| prev_pc_i | input | PC_W | PC of the completing operation |
| csr_we_i | input | 1 | Software write enable |
| csr_wdata_i | input | 9 | Software write data |
| csr_o | output | 9 | Register contents (enable and flags) |
| exc_req_o | output | 1 | Floating-point exception request pulse |
| exc_pc_o | output | PC_W | PC carried with the request |

## Verification
Each cause is driven alone, so that a wrong or missing fan-out shows up as a wrong flag bit. A misrouted NaN cause would set the wrong NaN flag or the infinity flag. A status report with no causes is sent while flags are already set, which catches a design that raises a request only for new flags or that lets a report clear flags. A write and a strobe are issued together, which exposes a design that merges the two or emits a stray request. A strobe sent with enable clear exposes a missing gate, which would show up as flags set under disable.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned CAUSE_W = 13;
  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned CSR_W   = FLAG_W + 1;

  // cause vector positions
  localparam int unsigned CI_SNAN = 0;
  localparam int unsigned CI_QNAN = 1;
  localparam int unsigned CI_ISI  = 2;
  localparam int unsigned CI_IDI  = 3;
  localparam int unsigned CI_ZDZ  = 4;
  localparam int unsigned CI_IMZ  = 5;
  localparam int unsigned CI_CVI  = 6;
  localparam int unsigned CI_CMP  = 7;
  localparam int unsigned CI_SQRT = 8;
  localparam int unsigned CI_OVF  = 9;
  localparam int unsigned CI_UNF  = 10;
  localparam int unsigned CI_DZ   = 11;
  localparam int unsigned CI_IX   = 12;

  // flag positions inside the flag field (csr bit = index + 1)
  localparam int unsigned FI_INV  = 0;
  localparam int unsigned FI_SNAN = 1;
  localparam int unsigned FI_QNAN = 2;
  localparam int unsigned FI_OVF  = 3;
  localparam int unsigned FI_UNF  = 4;
  localparam int unsigned FI_INF  = 5;
  localparam int unsigned FI_DZ   = 6;
  localparam int unsigned FI_IX   = 7;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [FLAG_W-1:0]  flags_t;

  typedef struct packed {
    flags_t flags;
    logic   en;
  } csr_t;
endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
  import fpx_pkg::*;
(
  input  cause_t cause_i,
  output flags_t set_o
);
  localparam int unsigned N_DIRECT = 4;
  localparam int unsigned DIRECT_CI [N_DIRECT] = '{CI_OVF, CI_UNF, CI_DZ, CI_IX};
  localparam int unsigned DIRECT_FI [N_DIRECT] = '{FI_OVF, FI_UNF, FI_DZ, FI_IX};

  flags_t folded;

  always_comb begin
    folded          = '0;
    folded[FI_INV]  = |cause_i[CI_SQRT:CI_SNAN];
    folded[FI_SNAN] = cause_i[CI_SNAN];
    folded[FI_QNAN] = cause_i[CI_QNAN];
    folded[FI_INF]  = cause_i[CI_ISI] | cause_i[CI_IDI];
  end

  for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
    logic direct;
    always_comb begin
      direct = 1'b0;
      for (int k = 0; k < N_DIRECT; k++)
        if (DIRECT_FI[k] == g) direct = direct | cause_i[DIRECT_CI[k]];
    end
    assign set_o[g] = folded[g] | direct;
  end
endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg
  import fpx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  csr_t   wdata_i,
  input  logic   upd_i,
  input  flags_t set_i,
  output csr_t   csr_o
);
  csr_t csr_q, csr_d;

  always_comb begin
    csr_d = csr_q;
    if (we_i)       csr_d = wdata_i;          // software wins
    else if (upd_i) csr_d.flags = csr_q.flags | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '0;
    else         csr_q <= csr_d;
  end

  assign csr_o = csr_q;
endmodule

// File: rtl/fpx_exc_gen.sv
module fpx_exc_gen #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            any_flag_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            req_o,
  output logic [PC_W-1:0] pc_o
);
  logic            req_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      req_q <= fire_i & any_flag_i;
      if (fire_i) pc_q <= pc_i;
    end
  end

  assign req_o = req_q;
  assign pc_o  = pc_q;
endmodule

// File: rtl/fpx_sticky_flags.sv
module fpx_sticky_flags
  import fpx_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  op_done_i,
  input  logic [CAUSE_W-1:0]    op_cause_i,
  input  logic [PC_W-1:0]       prev_pc_i,
  input  logic                  csr_we_i,
  input  logic [CSR_W-1:0]      csr_wdata_i,
  output logic [CSR_W-1:0]      csr_o,
  output logic                  exc_req_o,
  output logic [PC_W-1:0]       exc_pc_o
);
  csr_t   csr;
  flags_t set_flags;
  logic   accept;

  fpx_cause_map u_map (
    .cause_i (op_cause_i),
    .set_o   (set_flags)
  );

  assign accept = op_done_i & csr.en & ~csr_we_i;

  fpx_flag_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .wdata_i (csr_t'(csr_wdata_i)),
    .upd_i   (accept),
    .set_i   (set_flags),
    .csr_o   (csr)
  );

  fpx_exc_gen #(.PC_W(PC_W)) u_exc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (accept),
    .any_flag_i (|(csr.flags | set_flags)),
    .pc_i       (prev_pc_i),
    .req_o      (exc_req_o),
    .pc_o       (exc_pc_o)
  );

  assign csr_o = csr;
endmodule

// File: rtl/fpx_sticky_flags_chk.sv
module fpx_sticky_flags_chk
  import fpx_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_done_i,
  input logic [CAUSE_W-1:0] op_cause_i,
  input logic [PC_W-1:0]    prev_pc_i,
  input logic               csr_we_i,
  input logic [CSR_W-1:0]   csr_wdata_i,
  input logic [CSR_W-1:0]   csr_o,
  input logic               exc_req_o,
  input logic [PC_W-1:0]    exc_pc_o
);
  AST_GATED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && (!op_done_i || !csr_o[0])) |=> $stable(csr_o)); // R2
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> ((csr_o & $past(csr_o)) == $past(csr_o))); // R7
  AST_SW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i |=> (csr_o == $past(csr_wdata_i))); // R8
  AST_REQ_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> ($past(op_done_i) && !$past(csr_we_i) && $past(csr_o[0]))); // R10
  AST_REQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (csr_o[CSR_W-1:1] != '0)); // R9
  AST_REQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (exc_pc_o == $past(prev_pc_i))); // R9
  AST_SNAN_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && !op_cause_i[0] && !csr_o[2]) |=> !csr_o[2]); // R4
endmodule

bind fpx_sticky_flags fpx_sticky_flags_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_fpx_sticky_flags.sv
module sim_fpx_sticky_flags;
  localparam int PC_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_done = 1'b0;
  logic [12:0]      cause = '0;
  logic [PC_W-1:0]  ppc = '0;
  logic             we = 1'b0;
  logic [8:0]       wdata = '0;
  logic [8:0]       csr;
  logic             exc_req;
  logic [PC_W-1:0]  exc_pc;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [8:0] m_csr = '0;

  always #4 clk = ~clk;

  fpx_sticky_flags #(.PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_done_i(op_done), .op_cause_i(cause),
    .prev_pc_i(ppc), .csr_we_i(we), .csr_wdata_i(wdata),
    .csr_o(csr), .exc_req_o(exc_req), .exc_pc_o(exc_pc)
  );

  // flag field from causes, per R3..R6
  function automatic logic [7:0] fold(input logic [12:0] c);
    logic [7:0] f;
    f    = '0;
    f[0] = c[0] | c[1] | c[2] | c[3] | c[4] | c[5] | c[6] | c[7] | c[8];
    f[1] = c[0];
    f[2] = c[1];
    f[3] = c[9];
    f[4] = c[10];
    f[5] = c[2] | c[3];
    f[6] = c[11];
    f[7] = c[12];
    return f;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle at a negedge, check at the following negedge
  task automatic step(input string tag, input logic w, input logic [8:0] wd,
                      input logic d, input logic [12:0] c, input logic [PC_W-1:0] pc);
    logic [8:0] nxt;
    logic       ereq;
    we = w; wdata = wd; op_done = d; cause = c; ppc = pc;
    nxt  = m_csr;
    ereq = 1'b0;
    if (w) nxt = wd;
    else if (d && m_csr[0]) begin
      nxt[8:1] = m_csr[8:1] | fold(c);
      ereq = (nxt[8:1] != '0);
    end
    @(negedge clk);
    we = 1'b0; op_done = 1'b0; cause = '0;
    m_csr = nxt;
    check({tag, " csr"}, 64'(csr), 64'(nxt));
    check({tag, " req"}, 64'(exc_req), 64'(ereq));
    if (ereq) check({tag, " pc"}, 64'(exc_pc), 64'(pc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 csr", 64'(csr), 64'h0);
    check("R1 req", 64'(exc_req), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: disabled, full cause vector ignored
    step("R2", 1'b0, 9'h0, 1'b1, 13'h1fff, 32'h100);
    step("R8 enable", 1'b1, 9'h001, 1'b0, 13'h0, 32'h0);
    // R10: empty status with clear flags
    step("R10", 1'b0, 9'h0, 1'b1, 13'h0, 32'h104);
    // R4 signalling NaN, then idle cycle: pulse drops (R9)
    step("R4 snan", 1'b0, 9'h0, 1'b1, 13'h0001, 32'h200);
    step("R9 pulse end", 1'b0, 9'h0, 1'b0, 13'h0, 32'h0);
    // R3: each invalid cause alone
    for (int i = 0; i < 9; i++) begin
      step("R8 clear", 1'b1, 9'h001, 1'b0, 13'h0, 32'h0);
      step("R3 invalid cause", 1'b0, 9'h0, 1'b1, 13'(1 << i), 32'h300 + 32'(i));
    end
    step("R8 clear", 1'b1, 9'h001, 1'b0, 13'h0, 32'h0);
    step("R4 qnan", 1'b0, 9'h0, 1'b1, 13'h0002, 32'h400);
    step("R8 clear", 1'b1, 9'h001, 1'b0, 13'h0, 32'h0);
    step("R5 inf-inf", 1'b0, 9'h0, 1'b1, 13'h0004, 32'h404);
    step("R8 clear", 1'b1, 9'h001, 1'b0, 13'h0, 32'h0);
    step("R5 inf/inf", 1'b0, 9'h0, 1'b1, 13'h0008, 32'h408);
    for (int i = 9; i < 13; i++) begin
      step("R8 clear", 1'b1, 9'h001, 1'b0, 13'h0, 32'h0);
      step("R6 direct cause", 1'b0, 9'h0, 1'b1, 13'(1 << i), 32'h500 + 32'(i));
    end
    // R7: empty report keeps flags and still requests
    step("R7 sticky", 1'b0, 9'h0, 1'b1, 13'h0, 32'h600);
    // R8: write with strobe in same cycle
    step("R8 collide", 1'b1, 9'h001, 1'b1, 13'h1fff, 32'h700);
    step("R2 disable", 1'b1, 9'h1fe, 1'b0, 13'h0, 32'h0);
    step("R2 held", 1'b0, 9'h0, 1'b1, 13'h0, 32'h704);

    for (int n = 0; n < 3000; n++) begin
      logic w;
      logic d;
      w = ($urandom % 8) == 0;
      d = ($urandom % 2) == 0;
      step("R7 R9 random", w, 9'($urandom), d,
           13'($urandom & $urandom & $urandom), $urandom);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule